// File: doc/BRIEF.md
# Daisy-Chain Serial Result Sequencer

This block is the serial output stage of one converter in a chain of identical converters that share a single serial line toward a processor. On each sample start it sends its own 16-bit result for the current channel. After that it forwards the words of the devices upstream of it, one word per extra device in the chain, and then moves to the next enabled channel. Because every device does the same, the processor sees the results interleaved by device within each channel slot: all devices report channel A before any of them reports channel B.

A 3-bit chain-length code gives the number of devices minus one, so code 0 is a stand-alone device and code 7 is a chain of eight. A 6-bit enable mask picks the channels. Every device in a chain must be given the same mask, so that all of them step through the channels in the same order. The block shows on `chan_sel` which channel it will send next, so the conversion logic can present that channel's result on `result` before the start pulse.

Top module: `casc_out_seq`

## Requirements
- R1: When `start` is high at a clock edge while the block is idle and at least one mask bit is set, `out_fs` is high for exactly the next clock period, and `out_sd` carries `result` MSB first over the next 16 clock periods, starting in that same period.
- R2: Mask bit i enables channel i (i = 0..5). `chan_sel` is the binary index of the lowest-numbered enabled channel at or above the internal channel pointer, searching upward and wrapping past 5 to 0.
- R3: When a channel slot ends, the pointer moves to the channel after the one just sent. After the highest enabled channel, the next slot therefore wraps to the lowest enabled channel.
- R4: Chain-length code k (0..7) means k+1 devices. After the own word there is exactly one clock period with `out_fs` and `out_sd` low. The block then forwards exactly k upstream words, each of which begins with an `up_fs` pulse and is 16 bits long.
- R5: While forwarding, `out_sd` and `out_fs` equal `up_sd` and `up_fs` delayed by one clock.
- R6: With code 0 the block returns to idle straight after the quiet handover period, and forwards no upstream activity.
- R7: With an all-zero mask, `start` is ignored and `out_fs` and `out_sd` stay low.
- R8: A `start` pulse that arrives while a slot is in progress is ignored. The word in flight and the channel order are not affected.
- R9: After reset `out_fs` and `out_sd` are low and the channel pointer is 0.
- R10: Upstream frame syncs and data that arrive while the block is idle do not appear on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all outputs change on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Sample start pulse that begins a channel slot |
| chan_en | input | 6 | Channel enable mask, bit i enables channel i |
| casc_len | input | 3 | Number of chained devices minus one |
| result | input | 16 | Own result for the channel shown on `chan_sel` |
| up_fs | input | 1 | Frame sync from the upstream neighbour |
| up_sd | input | 1 | Serial data from the upstream neighbour |
| chan_sel | output | 3 | Index of the channel the next slot will send |
| out_fs | output | 1 | Frame sync toward the processor |
| out_sd | output | 1 | Serial data toward the processor |

## Verification
The bench builds the block with its default parameters: 16-bit words, six channels and a 3-bit chain-length code. With these values every chain length from one to eight devices is in reach, and so is the wrap from channel 5 back to channel 0. Random masks, lengths and data are mixed with directed cases: the empty mask, a single enabled channel that wraps onto itself, the longest chain, a start pulse inside a busy slot, and upstream traffic while the block is idle.

// File: rtl/casc_pkg.sv
package casc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OWN  = 2'd1,
    ST_FWD  = 2'd2
  } seq_st_t;
endpackage

// File: rtl/casc_chan_pick.sv
module casc_chan_pick #(
  parameter int N_CH  = 6,
  parameter int IDX_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0]  mask,
  input  logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] sel,
  output logic             any_en
);
  // first enabled channel at or after ptr, wrapping
  function automatic logic [IDX_W-1:0] first_from(input logic [N_CH-1:0] m,
                                                  input logic [IDX_W-1:0] p);
    logic [IDX_W-1:0] r;
    logic             hit;
    int               idx;
    r   = '0;
    hit = 1'b0;
    for (int k = 0; k < N_CH; k++) begin
      idx = (int'(p) + k) % N_CH;
      if (!hit && m[idx]) begin
        r   = IDX_W'(idx);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  assign any_en = |mask;
  assign sel    = first_from(mask, ptr);
endmodule

// File: rtl/casc_word_shift.sv
module casc_word_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         msb
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= din;
    else if (shift) sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign msb = sh_q[W-1];
endmodule

// File: rtl/casc_out_seq.sv
module casc_out_seq #(
  parameter int WORD_W = 16,
  parameter int N_CH   = 6,
  parameter int CL_W   = 3
) (
  input  logic                     sclk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [N_CH-1:0]          chan_en,
  input  logic [CL_W-1:0]          casc_len,
  input  logic [WORD_W-1:0]        result,
  input  logic                     up_fs,
  input  logic                     up_sd,
  output logic [$clog2(N_CH)-1:0]  chan_sel,
  output logic                     out_fs,
  output logic                     out_sd
);
  import casc_pkg::*;

  localparam int IDX_W = $clog2(N_CH);
  localparam int BC_W  = $clog2(WORD_W);

  function automatic logic [IDX_W-1:0] next_ptr(input logic [IDX_W-1:0] c);
    return (int'(c) == N_CH - 1) ? '0 : c + 1'b1;
  endfunction

  seq_st_t           st_q;
  logic [IDX_W-1:0]  ptr_q;
  logic [IDX_W-1:0]  cur_q;
  logic [BC_W-1:0]   own_cnt_q;
  logic [BC_W-1:0]   fwd_cnt_q;
  logic [CL_W-1:0]   rem_q;
  logic              fwd_fs_q, fwd_sd_q;
  logic              any_en, shift_msb;

  // named events
  logic go, own_done, fwd_done, own_first;
  assign go        = (st_q == ST_IDLE) && start && any_en;
  assign own_done  = (st_q == ST_OWN) && (own_cnt_q == '0);
  assign own_first = (st_q == ST_OWN) && (own_cnt_q == BC_W'(WORD_W - 1));
  assign fwd_done  = (st_q == ST_FWD) && !up_fs && (fwd_cnt_q == BC_W'(1)) && (rem_q == '0);

  casc_chan_pick #(.N_CH(N_CH), .IDX_W(IDX_W)) u_pick (
    .mask(chan_en), .ptr(ptr_q), .sel(chan_sel), .any_en(any_en)
  );

  casc_word_shift #(.W(WORD_W)) u_shift (
    .clk(sclk), .rst_n(rst_n), .load(go), .shift(st_q == ST_OWN),
    .din(result), .msb(shift_msb)
  );

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ptr_q     <= '0;
      cur_q     <= '0;
      own_cnt_q <= '0;
      fwd_cnt_q <= '0;
      rem_q     <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go) begin
          st_q      <= ST_OWN;
          cur_q     <= chan_sel;
          own_cnt_q <= BC_W'(WORD_W - 1);
        end
        ST_OWN: begin
          if (own_done) begin
            if (casc_len == '0) begin
              st_q  <= ST_IDLE;
              ptr_q <= next_ptr(cur_q);
            end else begin
              st_q      <= ST_FWD;
              rem_q     <= casc_len;
              fwd_cnt_q <= '0;
            end
          end else begin
            own_cnt_q <= own_cnt_q - 1'b1;
          end
        end
        ST_FWD: begin
          if (up_fs) begin
            fwd_cnt_q <= BC_W'(WORD_W - 1);
            if (rem_q != '0) rem_q <= rem_q - 1'b1;
          end else if (fwd_cnt_q != '0) begin
            fwd_cnt_q <= fwd_cnt_q - 1'b1;
          end
          if (fwd_done) begin
            st_q  <= ST_IDLE;
            ptr_q <= next_ptr(cur_q);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_fs_q <= 1'b0;
      fwd_sd_q <= 1'b0;
    end else begin
      fwd_fs_q <= (st_q == ST_FWD) && up_fs;
      fwd_sd_q <= (st_q == ST_FWD) && up_sd;
    end
  end

  assign out_sd = (st_q == ST_OWN) ? shift_msb : fwd_sd_q;
  assign out_fs = own_first | fwd_fs_q;

  AST_START_FS: assert property (@(posedge sclk) disable iff (!rst_n)
    go |=> (out_fs && out_sd == $past(result[WORD_W-1]))); // R1
  AST_FS_SINGLE: assert property (@(posedge sclk) disable iff (!rst_n)
    (st_q == ST_OWN && out_fs) |=> !out_fs); // R1
  AST_CH_ENABLED: assert property (@(posedge sclk) disable iff (!rst_n)
    go |-> chan_en[chan_sel]); // R2
  AST_FWD_COPY: assert property (@(posedge sclk) disable iff (!rst_n)
    (st_q == ST_FWD) |=> (out_sd == $past(up_sd) && out_fs == $past(up_fs))); // R5
  AST_HANDOVER_GAP: assert property (@(posedge sclk) disable iff (!rst_n)
    own_done |=> (!out_fs && !out_sd)); // R4
  AST_SOLO_IDLE: assert property (@(posedge sclk) disable iff (!rst_n)
    (own_done && casc_len == '0) |=> (st_q == ST_IDLE)); // R6
  AST_IDLE_QUIET: assert property (@(posedge sclk) disable iff (!rst_n)
    (st_q == ST_IDLE && !go) |=> (!out_fs && !out_sd)); // R7
endmodule

// File: tb/casc_out_seq_tb_top.sv
module casc_out_seq_tb_top;
  logic        sclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  chan_en = '0;
  logic [2:0]  casc_len = '0;
  logic [15:0] result = '0;
  logic        up_fs = 1'b0, up_sd = 1'b0;
  logic [2:0]  chan_sel;
  logic        out_fs, out_sd;

  int checks = 0;
  int errors = 0;
  int exp_ptr = 0;
  int cycles = 0;

  always #4 sclk = ~sclk;

  casc_out_seq dut_i (
    .sclk(sclk), .rst_n(rst_n), .start(start), .chan_en(chan_en),
    .casc_len(casc_len), .result(result), .up_fs(up_fs), .up_sd(up_sd),
    .chan_sel(chan_sel), .out_fs(out_fs), .out_sd(out_sd)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected channel: walk upward from pointer until an enabled bit is found
  function automatic int exp_chan(input logic [5:0] m, input int p);
    int c = p;
    int n = 0;
    while (n < 6 && !m[c]) begin
      c = (c == 5) ? 0 : c + 1;
      n++;
    end
    return c;
  endfunction

  task automatic run_slot(input logic [5:0] m, input logic [2:0] len,
                          input logic [15:0] d, input bit busy_kick);
    int ec;
    logic [15:0] w;
    chan_en  = m;
    casc_len = len;
    result   = d;
    #1;
    ec = exp_chan(m, exp_ptr);
    chk(chan_sel == 3'(ec), "R2 chan_sel", chan_sel, ec);
    start = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge sclk);
      start = busy_kick && (i == 6);
      chk(out_fs == (i == 0), "R1 own fs", out_fs, i == 0);
      chk(out_sd == d[15-i], "R1 own bit", out_sd, d[15-i]);
    end
    start = 1'b0;
    @(negedge sclk);
    chk(!out_fs && !out_sd, "R4 handover gap", {out_fs, out_sd}, 0);
    for (int k = 0; k < int'(len); k++) begin
      w = 16'($urandom);
      for (int i = 0; i < 16; i++) begin
        up_fs = (i == 0);
        up_sd = w[15-i];
        @(negedge sclk);
        chk(out_fs == (i == 0), "R5 fwd fs", out_fs, i == 0);
        chk(out_sd == w[15-i], "R5 fwd bit", out_sd, w[15-i]);
      end
    end
    // trailing upstream traffic must not reach the outputs (R6, R10)
    up_fs = 1'b1; up_sd = 1'b1;
    @(negedge sclk);
    up_fs = 1'b0;
    chk(!out_fs, "R4 word count / R6 no extra fwd", out_fs, 0);
    @(negedge sclk);
    up_sd = 1'b0;
    chk(!out_fs && !out_sd, "R10 idle ignores upstream", {out_fs, out_sd}, 0);
    exp_ptr = (ec == 5) ? 0 : ec + 1;
    #1;
    if (m != 0) begin
      ec = exp_chan(m, exp_ptr);
      chk(chan_sel == 3'(ec), "R3 pointer advance", chan_sel, ec);
    end
  endtask

  initial begin
    forever begin
      @(posedge sclk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge sclk);
    chk(!out_fs && !out_sd, "R9 reset outputs", {out_fs, out_sd}, 0);
    chan_en = 6'b000001;
    #1;
    chk(chan_sel == 3'd0, "R9 reset pointer", chan_sel, 0);
    rst_n = 1'b1;
    @(negedge sclk);

    // R7: empty mask ignores start
    chan_en = '0;
    start = 1'b1;
    @(negedge sclk);
    start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge sclk);
      chk(!out_fs && !out_sd, "R7 empty mask quiet", {out_fs, out_sd}, 0);
    end

    // directed: solo device, all channels, wrap 5->0 (R3, R6)
    for (int s = 0; s < 7; s++) run_slot(6'b111111, 3'd0, 16'hA5C3 ^ 16'(s), 1'b0);
    // single channel wraps onto itself (R3)
    run_slot(6'b001000, 3'd0, 16'h8001, 1'b0);
    run_slot(6'b001000, 3'd0, 16'h7FFE, 1'b0);
    // longest chain (R4)
    run_slot(6'b100100, 3'd7, 16'hFFFF, 1'b0);
    // start while busy (R8)
    run_slot(6'b010010, 3'd2, 16'h1234, 1'b1);
    run_slot(6'b010010, 3'd0, 16'h4321, 1'b1);

    // random mix
    for (int s = 0; s < 40; s++) begin
      logic [5:0] m;
      m = 6'($urandom);
      if (m == 0) m = 6'b000001;
      run_slot(m, 3'($urandom), 16'($urandom), 1'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule